// File: doc/BRIEF.md
# DMA Dispatcher Control and Status Registers

This block is the register front end of a descriptor-driven DMA dispatcher. Software reaches it through a simple 32-bit register bus with two words. The status word sits at offset 0x00 and the control word sits at offset 0x04. The engine itself stays outside the block. It reports its busy state and its queue levels as live signals. It reports completions, errors and early terminations as single-cycle pulses, and each pulse comes with the interrupt flags of the descriptor that caused it.

The block holds the sticky event flags. It drives a single interrupt line, and it decides when dispatch must halt. Status bits 0 to 4 are live. The remaining flags are sticky and software clears them by writing ones.

Setting the reset bit in the control word starts a soft reset. The block then emits a one-cycle reset pulse towards the engine and shows a resetting flag. That flag drops when the engine acknowledges, or after a fixed number of cycles at most.

Top module: `dispatch_csr`

## Requirements
- R1: After reset, both registers read zero apart from the live level bits, and irq, stop_req and soft_rst are low.
- R2: Status bits 0 to 4 follow eng_busy, desc_empty, desc_full, resp_empty and resp_full in that order, one bit each. Writes to these bits have no effect on them.
- R3: A completion pulse sets the pending bit (status bit 9) only when done_irq is high in the same cycle.
- R4: An error pulse sets the pending bit only when err_code AND err_irq_mask (8 bits each) is nonzero.
- R5: An early-termination pulse sets the pending bit only when early_irq is high in the same cycle.
- R6: Writing a one to status bit 9 clears the pending bit, and writing a zero there leaves it unchanged. When a setting event arrives in the same cycle as the clear, the bit ends up set.
- R7: irq is high exactly when the pending bit is set and the global enable (control bit 4) is set. The pending bit is kept while the enable is off.
- R8: With stop-on-error (control bit 2) set, an error pulse sets status bits 7 and 5 and raises stop_req. Writing a one to status bit 7 clears that flag. With the enable off, an error leaves bit 7 low.
- R9: With stop-on-early (control bit 3) set, an early pulse sets status bits 8 and 5 and raises stop_req. Writing a one to status bit 8 clears that flag. With the enable off, bit 8 stays low.
- R10: Control bits 0, 2, 3, 4 and 5 read back as written. stop_req and status bit 5 are both high while control bit 0, control bit 5, status bit 7 or status bit 8 is set.
- R11: A write of control bit 1 while no reset runs does the following:
  - it gives soft_rst for one cycle;
  - it raises status bit 6, which also reads back as control bit 1;
  - it clears control bits 0 and 5 and status bits 7 and 8;
  - it loads control bits 2 to 4 from the written data;
  - it keeps the pending bit.
- R12: The resetting flag drops in the cycle after rst_done is seen. Without rst_done, it stays high for exactly RST_CYCLES cycles.
- R13: Completion, error and early pulses are ignored while the resetting flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address (0x00 status, 0x04 control) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| eng_busy | input | 1 | Engine busy level |
| desc_empty | input | 1 | Descriptor queue empty level |
| desc_full | input | 1 | Descriptor queue full level |
| resp_empty | input | 1 | Response queue empty level |
| resp_full | input | 1 | Response queue full level |
| evt_done | input | 1 | Descriptor completed pulse |
| done_irq | input | 1 | Completed descriptor requests an interrupt |
| evt_err | input | 1 | Error pulse |
| err_code | input | ERR_W | Error bits of the failing transfer |
| err_irq_mask | input | ERR_W | Descriptor's error-interrupt mask |
| evt_early | input | 1 | Early termination pulse |
| early_irq | input | 1 | Descriptor requests an interrupt on early end |
| rst_done | input | 1 | Engine acknowledges soft reset |
| irq | output | 1 | Interrupt line |
| stop_req | output | 1 | Halt dispatch request |
| soft_rst | output | 1 | One-cycle soft reset pulse to the engine |

## Verification
The bench sweeps all 256 error codes against a set of masks, so a design that tested only one bit or OR-ed the mask would set pending wrongly. It places a clear and a setting event in the same cycle, which exposes a design that lets the clear win and loses an interrupt. It also turns the global enable off and on again around a pending event, which catches a design that gates the stored bit rather than the output. During a soft reset it fires every event kind and counts the resetting cycles one by one. An off-by-one timeout, or a design that still latches events or stop flags during reset, shows up there as a wrong status word.

// File: rtl/dispatch_csr_pkg.sv
`timescale 1ns/1ps
// Shared bit positions and types for the dispatcher register block.
// Assumes a 32-bit register word and word-aligned byte addresses.
package dispatch_csr_pkg;
    localparam int DATA_W = 32;

    // status word bit positions
    localparam int ST_BUSY       = 0;
    localparam int ST_DQ_EMPTY   = 1;
    localparam int ST_DQ_FULL    = 2;
    localparam int ST_RQ_EMPTY   = 3;
    localparam int ST_RQ_FULL    = 4;
    localparam int ST_STOPPED    = 5;
    localparam int ST_RESETTING  = 6;
    localparam int ST_STOP_ERR   = 7;
    localparam int ST_STOP_EARLY = 8;
    localparam int ST_PEND       = 9;

    // control word bit positions
    localparam int CT_STOP       = 0;
    localparam int CT_RESET      = 1;
    localparam int CT_ERR_EN     = 2;
    localparam int CT_EARLY_EN   = 3;
    localparam int CT_GIE        = 4;
    localparam int CT_FETCH_HOLD = 5;

    // byte offsets of the two registers
    localparam int OFS_STATUS = 0;
    localparam int OFS_CTRL   = 4;

    typedef struct packed {
        logic fetch_hold;
        logic gie;
        logic early_en;
        logic err_en;
        logic stop;
    } ctrl_t;
endpackage

// File: rtl/dispatch_csr_rstseq.sv
`timescale 1ns/1ps
// Soft reset sequencer: on start, emits a one-cycle pulse and holds the
// resetting flag until the engine acknowledges or RST_CYCLES elapse.
// Assumes start is only meaningful while idle; a start while busy is ignored.
module dispatch_csr_rstseq #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ack,
    output logic resetting,
    output logic pulse
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // resetting flag, cycle counter and outgoing pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resetting <= 1'b0;
            pulse     <= 1'b0;
            cnt       <= '0;
        end else begin
            pulse <= start && !resetting;
            if (!resetting) begin
                if (start) begin
                    resetting <= 1'b1;
                    cnt       <= '0;
                end
            end else if (ack || cnt == LAST) begin
                resetting <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dispatch_csr_sticky.sv
`timescale 1ns/1ps
// Sticky event flags: interrupt pending and the two stop-cause flags.
// A setting event wins over a same-cycle write-one-to-clear; a reset
// start (purge) wins over everything for the stop flags. Events are
// dropped while hold is high.
module dispatch_csr_sticky #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             purge,
    input  logic             evt_done,
    input  logic             done_irq,
    input  logic             evt_err,
    input  logic [ERR_W-1:0] err_code,
    input  logic [ERR_W-1:0] err_mask,
    input  logic             evt_early,
    input  logic             early_irq,
    input  logic             err_en,
    input  logic             early_en,
    input  logic             clr_pend,
    input  logic             clr_err,
    input  logic             clr_early,
    output logic             pend,
    output logic             stop_err,
    output logic             stop_early
);
    logic set_pend, set_err, set_early;

    // qualify incoming events by descriptor flags and enables
    always_comb begin
        set_pend  = !hold && ((evt_done && done_irq)
                           || (evt_err && |(err_code & err_mask))
                           || (evt_early && early_irq));
        set_err   = !hold && evt_err && err_en;
        set_early = !hold && evt_early && early_en;
    end

    // interrupt pending flag: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (set_pend) pend <= 1'b1;
        else if (clr_pend) pend <= 1'b0;
    end

    // stop-cause flags: purge, then set, then clear
    always_ff @(posedge clk) begin
        if (!rst_n || purge) begin
            stop_err   <= 1'b0;
            stop_early <= 1'b0;
        end else begin
            if (set_err)        stop_err <= 1'b1;
            else if (clr_err)   stop_err <= 1'b0;
            if (set_early)      stop_early <= 1'b1;
            else if (clr_early) stop_early <= 1'b0;
        end
    end
endmodule

// File: rtl/dispatch_csr.sv
`timescale 1ns/1ps
// Dispatcher control/status register block (top).
// Decodes a two-word register bus, holds the control word, assembles the
// status word from live engine levels and sticky flags, and drives the
// interrupt, stop request and soft reset pulse. Assumes single-cycle
// writes and combinational reads.
module dispatch_csr
    import dispatch_csr_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int ERR_W      = 8,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_busy,
    input  logic              desc_empty,
    input  logic              desc_full,
    input  logic              resp_empty,
    input  logic              resp_full,
    input  logic              evt_done,
    input  logic              done_irq,
    input  logic              evt_err,
    input  logic [ERR_W-1:0]  err_code,
    input  logic [ERR_W-1:0]  err_irq_mask,
    input  logic              evt_early,
    input  logic              early_irq,
    input  logic              rst_done,
    output logic              irq,
    output logic              stop_req,
    output logic              soft_rst
);
    ctrl_t ctrl_q;
    logic  sel_status, sel_ctrl, wr_status, wr_ctrl, rst_go;
    logic  resetting, pend, stop_err, stop_early;
    logic  clr_pend, clr_err, clr_early;
    logic [DATA_W-1:0] status_w, ctrl_w;
    wire   unused_wdata = ^{reg_wdata[DATA_W-1:ST_PEND+1], reg_wdata[ST_RESETTING]};

    // address decode and write strobes
    always_comb begin
        sel_status = (reg_addr == ADDR_W'(OFS_STATUS));
        sel_ctrl   = (reg_addr == ADDR_W'(OFS_CTRL));
        wr_status  = reg_wr && sel_status;
        wr_ctrl    = reg_wr && sel_ctrl;
        rst_go     = wr_ctrl && reg_wdata[CT_RESET] && !resetting;
        clr_pend   = wr_status && reg_wdata[ST_PEND];
        clr_err    = wr_status && reg_wdata[ST_STOP_ERR];
        clr_early  = wr_status && reg_wdata[ST_STOP_EARLY];
    end

    // control word: reset start clears the stop bits, keeps enables from data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.err_en     <= reg_wdata[CT_ERR_EN];
            ctrl_q.early_en   <= reg_wdata[CT_EARLY_EN];
            ctrl_q.gie        <= reg_wdata[CT_GIE];
            ctrl_q.stop       <= rst_go ? 1'b0 : reg_wdata[CT_STOP];
            ctrl_q.fetch_hold <= rst_go ? 1'b0 : reg_wdata[CT_FETCH_HOLD];
        end
    end

    dispatch_csr_rstseq #(.RST_CYCLES(RST_CYCLES)) u_rstseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rst_go),
        .ack       (rst_done),
        .resetting (resetting),
        .pulse     (soft_rst)
    );

    dispatch_csr_sticky #(.ERR_W(ERR_W)) u_sticky (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (resetting),
        .purge      (rst_go),
        .evt_done   (evt_done),
        .done_irq   (done_irq),
        .evt_err    (evt_err),
        .err_code   (err_code),
        .err_mask   (err_irq_mask),
        .evt_early  (evt_early),
        .early_irq  (early_irq),
        .err_en     (ctrl_q.err_en),
        .early_en   (ctrl_q.early_en),
        .clr_pend   (clr_pend),
        .clr_err    (clr_err),
        .clr_early  (clr_early),
        .pend       (pend),
        .stop_err   (stop_err),
        .stop_early (stop_early)
    );

    // halt request and gated interrupt line
    always_comb begin
        stop_req = ctrl_q.stop || ctrl_q.fetch_hold || stop_err || stop_early;
        irq      = pend && ctrl_q.gie;
    end

    // assemble status and control read words
    always_comb begin
        status_w                = '0;
        status_w[ST_BUSY]       = eng_busy;
        status_w[ST_DQ_EMPTY]   = desc_empty;
        status_w[ST_DQ_FULL]    = desc_full;
        status_w[ST_RQ_EMPTY]   = resp_empty;
        status_w[ST_RQ_FULL]    = resp_full;
        status_w[ST_STOPPED]    = stop_req;
        status_w[ST_RESETTING]  = resetting;
        status_w[ST_STOP_ERR]   = stop_err;
        status_w[ST_STOP_EARLY] = stop_early;
        status_w[ST_PEND]       = pend;
        ctrl_w                  = '0;
        ctrl_w[CT_STOP]         = ctrl_q.stop;
        ctrl_w[CT_RESET]        = resetting;
        ctrl_w[CT_ERR_EN]       = ctrl_q.err_en;
        ctrl_w[CT_EARLY_EN]     = ctrl_q.early_en;
        ctrl_w[CT_GIE]          = ctrl_q.gie;
        ctrl_w[CT_FETCH_HOLD]   = ctrl_q.fetch_hold;
    end

    // read mux
    always_comb begin
        if (sel_status)    reg_rdata = status_w;
        else if (sel_ctrl) reg_rdata = ctrl_w;
        else               reg_rdata = '0;
    end
endmodule

// File: rtl/dispatch_csr_chk.sv
`timescale 1ns/1ps
// Property checker for dispatch_csr, attached by bind below.
// Observes the event inputs, the decoded clear/start strobes and the
// sticky/sequencer state driven by the submodules.
module dispatch_csr_chk (
    input logic clk,
    input logic rst_n,
    input logic evt_done,
    input logic done_irq,
    input logic evt_err,
    input logic err_hit,
    input logic evt_early,
    input logic early_irq,
    input logic err_en,
    input logic rst_go,
    input logic clr_pend,
    input logic resetting,
    input logic rst_done,
    input logic soft_rst,
    input logic pend,
    input logic stop_req
);
    p_done_sets_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done && done_irq && !resetting) |=> pend);

    p_err_sets_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_err && err_hit && !resetting) |=> pend);

    p_early_sets_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_early && early_irq && !resetting) |=> pend);

    p_clear_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend && !evt_done && !evt_err && !evt_early) |=> !pend);

    p_stop_on_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_err && err_en && !resetting && !rst_go) |=> stop_req);

    p_rst_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    p_rst_enter_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resetting) |-> soft_rst);

    p_ack_ends_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (resetting && rst_done) |=> !resetting);

    p_ignore_events_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (resetting && !pend) |=> !pend);
endmodule

bind dispatch_csr dispatch_csr_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_done  (evt_done),
    .done_irq  (done_irq),
    .evt_err   (evt_err),
    .err_hit   (|(err_code & err_irq_mask)),
    .evt_early (evt_early),
    .early_irq (early_irq),
    .err_en    (ctrl_q.err_en),
    .rst_go    (rst_go),
    .clr_pend  (clr_pend),
    .resetting (resetting),
    .rst_done  (rst_done),
    .soft_rst  (soft_rst),
    .pend      (pend),
    .stop_req  (stop_req)
);

// File: tb/test_dispatch_csr.sv
`timescale 1ns/1ps
// Self-checking bench for dispatch_csr: sweeps levels, error codes and
// masks, control words, and walks the soft reset sequence cycle by cycle.
module test_dispatch_csr;
    localparam int RST_CYCLES = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_busy = 0, desc_empty = 0, desc_full = 0, resp_empty = 0, resp_full = 0;
    logic        evt_done = 0, done_irq = 0, evt_err = 0, evt_early = 0, early_irq = 0;
    logic [7:0]  err_code = '0, err_irq_mask = '0;
    logic        rst_done = 0;
    logic        irq, stop_req, soft_rst;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    dispatch_csr #(.ADDR_W(4), .ERR_W(8), .RST_CYCLES(RST_CYCLES)) i_dispatch_csr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
        .desc_empty(desc_empty), .desc_full(desc_full), .resp_empty(resp_empty),
        .resp_full(resp_full), .evt_done(evt_done), .done_irq(done_irq),
        .evt_err(evt_err), .err_code(err_code), .err_irq_mask(err_irq_mask),
        .evt_early(evt_early), .early_irq(early_irq), .rst_done(rst_done),
        .irq(irq), .stop_req(stop_req), .soft_rst(soft_rst)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse_done(input logic f);
        evt_done = 1'b1; done_irq = f;
        @(negedge clk);
        evt_done = 1'b0; done_irq = 1'b0;
    endtask

    task automatic pulse_err(input logic [7:0] c, input logic [7:0] m);
        evt_err = 1'b1; err_code = c; err_irq_mask = m;
        @(negedge clk);
        evt_err = 1'b0; err_code = '0; err_irq_mask = '0;
    endtask

    task automatic pulse_early(input logic f);
        evt_early = 1'b1; early_irq = f;
        @(negedge clk);
        evt_early = 1'b0; early_irq = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        rd(0, d); chk("R1 status", d, 32'h0);
        rd(4, d); chk("R1 ctrl", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 stop_req", {31'b0, stop_req}, 32'h0);
        chk("R1 soft_rst", {31'b0, soft_rst}, 32'h0);

        // R2 live level bits, writes ignored
        for (int v = 0; v < 32; v++) begin
            {resp_full, resp_empty, desc_full, desc_empty, eng_busy} = 5'(v);
            rd(0, d); chk("R2 levels", d, 32'(v));
            wr(0, 32'h1F);
            rd(0, d); chk("R2 write ignored", d, 32'(v));
        end
        {resp_full, resp_empty, desc_full, desc_empty, eng_busy} = '0;

        // R3 completion flag, R7 irq follows with enable on, R6 clear
        wr(4, 32'h10);
        for (int f = 0; f < 2; f++) begin
            pulse_done(1'(f));
            rd(0, d); chk("R3 done pend", {31'b0, d[9]}, 32'(f));
            chk("R7 irq on done", {31'b0, irq}, 32'(f));
            wr(0, 32'h200);
            rd(0, d); chk("R6 w1c pend", {31'b0, d[9]}, 32'h0);
        end

        // R4 error code versus mask sweep
        for (int mi = 0; mi < 10; mi++) begin
            logic [7:0] m;
            m = (mi == 0) ? 8'h00 : (mi == 1) ? 8'hFF : 8'(1 << (mi - 2));
            for (int c = 0; c < 256; c++) begin
                logic exp_p;
                exp_p = |(8'(c) & m);
                pulse_err(8'(c), m);
                rd(0, d); chk("R4 err pend", {31'b0, d[9]}, {31'b0, exp_p});
                if (d[9]) wr(0, 32'h200);
            end
        end

        // R5 early termination flag
        for (int f = 0; f < 2; f++) begin
            pulse_early(1'(f));
            rd(0, d); chk("R5 early pend", {31'b0, d[9]}, 32'(f));
            wr(0, 32'h200);
        end

        // R6 set wins over clear in the same cycle; writing zero keeps it
        evt_done = 1'b1; done_irq = 1'b1;
        reg_addr = 0; reg_wdata = 32'h200; reg_wr = 1'b1;
        cyc();
        evt_done = 1'b0; done_irq = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        rd(0, d); chk("R6 set beats clear", {31'b0, d[9]}, 32'h1);
        wr(0, 32'h0);
        rd(0, d); chk("R6 zero write keeps", {31'b0, d[9]}, 32'h1);
        wr(0, 32'h200);

        // R7 masking keeps the pending bit
        wr(4, 32'h0);
        pulse_done(1'b1);
        chk("R7 masked irq", {31'b0, irq}, 32'h0);
        rd(0, d); chk("R7 pend kept", {31'b0, d[9]}, 32'h1);
        wr(4, 32'h10);
        chk("R7 unmasked irq", {31'b0, irq}, 32'h1);
        wr(0, 32'h200);
        chk("R7 irq cleared", {31'b0, irq}, 32'h0);
        wr(4, 32'h0);

        // R8 stop on error
        wr(4, 32'h04);
        pulse_err(8'h01, 8'h00);
        rd(0, d); chk("R8 stop flags", d, 32'h0A0);
        chk("R8 stop_req", {31'b0, stop_req}, 32'h1);
        wr(0, 32'h080);
        rd(0, d); chk("R8 w1c", d, 32'h0);
        chk("R8 stop_req clear", {31'b0, stop_req}, 32'h0);
        wr(4, 32'h0);
        pulse_err(8'h01, 8'h00);
        rd(0, d); chk("R8 disabled", d, 32'h0);

        // R9 stop on early termination
        wr(4, 32'h08);
        pulse_early(1'b0);
        rd(0, d); chk("R9 stop flags", d, 32'h120);
        chk("R9 stop_req", {31'b0, stop_req}, 32'h1);
        wr(0, 32'h100);
        rd(0, d); chk("R9 w1c", d, 32'h0);
        wr(4, 32'h0);
        pulse_early(1'b0);
        rd(0, d); chk("R9 disabled", d, 32'h0);

        // R10 control readback and stop request
        for (int v = 0; v < 64; v++) begin
            if (v[1]) continue;
            wr(4, 32'(v));
            rd(4, d); chk("R10 readback", d, 32'(v));
            chk("R10 stop_req", {31'b0, stop_req}, {31'b0, (v[0] | v[5])});
            rd(0, d); chk("R10 stopped bit", {31'b0, d[5]}, {31'b0, (v[0] | v[5])});
        end
        wr(4, 32'h0);

        // R11 soft reset start
        wr(4, 32'h25);
        pulse_err(8'h00, 8'h00);
        pulse_done(1'b1);
        rd(0, d); chk("R11 pre state", d, 32'h2A0);
        reg_addr = 4; reg_wdata = 32'h1E; reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0; reg_wdata = '0;
        chk("R11 soft_rst pulse", {31'b0, soft_rst}, 32'h1);
        rd(4, d); chk("R11 ctrl after start", d, 32'h1E);
        rd(0, d); chk("R11 status after start", d, 32'h240);
        chk("R11 stop_req cleared", {31'b0, stop_req}, 32'h0);
        chk("R11 irq keeps pend", {31'b0, irq}, 32'h1);
        cyc();
        chk("R11 soft_rst one cycle", {31'b0, soft_rst}, 32'h0);
        wr(0, 32'h200);

        // R13 events ignored while resetting
        pulse_done(1'b1);
        pulse_err(8'hFF, 8'hFF);
        pulse_early(1'b1);
        rd(0, d); chk("R13 events ignored", d, 32'h040);
        chk("R13 no stop", {31'b0, stop_req}, 32'h0);

        // R12 timeout length: six samples so far showed resetting
        cnt = 6;
        for (int k = 0; k < 100; k++) begin
            cyc();
            rd(0, d);
            if (d[6]) cnt++;
            else break;
        end
        chk("R12 timeout cycles", 32'(cnt), 32'(RST_CYCLES));
        rd(4, d); chk("R12 ctrl after timeout", d, 32'h1C);

        // R12 engine acknowledge ends reset early
        wr(4, 32'h12);
        cyc(); cyc();
        rd(0, d); chk("R12 still resetting", {31'b0, d[6]}, 32'h1);
        rst_done = 1'b1;
        cyc();
        rst_done = 1'b0;
        rd(0, d); chk("R12 ack ends reset", {31'b0, d[6]}, 32'h0);
        rd(4, d); chk("R12 ctrl after ack", d, 32'h10);

        finished = 1;
        summary();
        $finish;
    end
endmodule